// File: doc/BRIEF.md
# Oscillator Enable and Stabilization Controller

This block switches two clock oscillators (a slow one and a fast one) on and off and decides when the system clock may move onto one of them. Software writes one enable bit per oscillator. When an oscillator is switched on, a counter in that oscillator's own clock domain counts its edges, starting only once the oscillator reports valid output. After a fixed number of edges it sets a sticky done flag. That flag crosses into the system clock domain through two flops and becomes the oscillator's ready output.

A request to move the system clock to a source is held pending until that source is ready. It is then committed, and a one-cycle change pulse tells the downstream glitch-free multiplexer to hand over. The block refuses to stop the oscillator that feeds the system clock. A write that clears its enable bit leaves the bit at 1. Clearing the enable of an unused oscillator drops its ready flag and restarts its count from zero.

Top module: `osc_stab_ctrl`

## Requirements
- R1: After reset, `osc_en` is 2'b00, `osc_rdy` is 2'b00, `sys_sel` is 0 (the boot source) and `sel_chg` is 0.
- R2: On a cycle with `en_wr` high, `osc_en` takes `en_wdata` from the next cycle on. Bit 0 controls the slow oscillator and bit 1 controls the fast one. Only R7 overrides this.
- R3: The slow oscillator's ready flag (`osc_rdy[0]`) stays low until `LO_STAB` (default 256) valid rising edges of `osc_clk[0]` have occurred since it was enabled. It rises within two system clocks after the edge that completes the count, and it then stays high while the oscillator remains enabled.
- R4: The fast oscillator's ready flag (`osc_rdy[1]`) follows the same rule with `HI_STAB` (default 64) edges of `osc_clk[1]`.
- R5: An oscillator edge that arrives while that oscillator's `osc_valid` bit is low is not counted, which models the oscillator's start-up time.
- R6: `sel_wdata` encodes the requested source: 0 is the boot source, 1 is the slow oscillator and 2 is the fast oscillator. A request written with `sel_wr` is held until the target is ready; the boot source is always ready. `sys_sel` takes the requested code on the cycle after the target's ready flag is seen high.
- R7: An enable write that would clear the bit of the oscillator selected by `sys_sel` leaves that bit at 1. The same applies to the oscillator being committed in that same cycle.
- R8: Clearing the enable of an oscillator that is not selected clears its ready flag by the next cycle. When it is enabled again, it needs the full stabilization count once more before it is ready.
- R9: `sel_chg` is high for exactly the one cycle in which `sys_sel` has just changed. A committed request for the source that is already selected does not raise it.
- R10: Code 3 on `sel_wdata` is reserved and is ignored. A newer valid request replaces a pending one that has not yet been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the oscillator enable bits |
| en_wdata | input | 2 | Enable data: bit 0 is the slow oscillator, bit 1 is the fast oscillator |
| sel_wr | input | 1 | Write strobe for the system clock source request |
| sel_wdata | input | 2 | Requested source: 0 is boot, 1 is slow, 2 is fast, 3 is ignored |
| osc_clk | input | 2 | Oscillator clocks: bit 0 is slow, bit 1 is fast |
| osc_valid | input | 2 | Oscillator output valid, low during start-up |
| osc_en | output | 2 | Oscillator enables, which also read back as the enable bits |
| osc_rdy | output | 2 | Per-oscillator ready flags in the system clock domain |
| sys_sel | output | 2 | Safe system clock source select |
| sel_chg | output | 1 | One-cycle pulse when `sys_sel` changes |

## Verification
On every cycle the assertions check four properties. The selected oscillator is always enabled and ready. A ready flag never stands without its enable. The reserved code never appears on `sys_sel`. `sel_chg` and a change of `sys_sel` always go together. They also check that an enable write can never stop the selected oscillator.

Only the bench scenarios can show the timing of the stabilization wait. These scenarios cover:
- edges that arrive while valid is low are not counted;
- a disabled and then re-enabled oscillator must wait the full count again;
- a pending request waits and is overridden correctly.

The bench checks these against a behavioural model that runs in both clock domains.

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl #(
  parameter int LO_STAB = 256,
  parameter int HI_STAB = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic [1:0] en_wdata,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic [1:0] osc_clk,
  input  logic [1:0] osc_valid,
  output logic [1:0] osc_en,
  output logic [1:0] osc_rdy,
  output logic [1:0] sys_sel,
  output logic       sel_chg
);

  localparam int MAX_STAB = (LO_STAB > HI_STAB) ? LO_STAB : HI_STAB;
  localparam int CNT_W    = $clog2(MAX_STAB + 1);
  localparam logic [1:0] SEL_BOOT = 2'd0;
  localparam logic [1:0] SEL_LO   = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;
  localparam logic [1:0] SEL_RSV  = 2'd3;

  logic       pend;
  logic [1:0] pend_sel;
  logic       req_ok, tgt_rdy, commit;
  logic [1:0] keep;

  assign req_ok  = sel_wr && (sel_wdata != SEL_RSV);
  assign tgt_rdy = (pend_sel == SEL_BOOT) ||
                   (pend_sel == SEL_LO && osc_rdy[0]) ||
                   (pend_sel == SEL_HI && osc_rdy[1]);
  assign commit  = pend && tgt_rdy && !req_ok;
  assign keep[0] = (sys_sel == SEL_LO) || (commit && pend_sel == SEL_LO);
  assign keep[1] = (sys_sel == SEL_HI) || (commit && pend_sel == SEL_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      osc_en <= 2'b00;
    else if (en_wr)  osc_en <= en_wdata | keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_sel <= SEL_BOOT;
      sys_sel  <= SEL_BOOT;
      sel_chg  <= 1'b0;
    end else begin
      sel_chg <= 1'b0;
      if (req_ok) begin
        pend     <= 1'b1;
        pend_sel <= sel_wdata;
      end else if (commit) begin
        pend    <= 1'b0;
        sys_sel <= pend_sel;
        sel_chg <= (pend_sel != sys_sel);
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_osc
    localparam int STAB = (i == 0) ? LO_STAB : HI_STAB;
    logic             arst_n;
    logic [CNT_W-1:0] cnt;
    logic             done, sync1, sync2;

    assign arst_n = rst_n & osc_en[i];

    always_ff @(posedge osc_clk[i] or negedge arst_n) begin
      if (!arst_n) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (osc_valid[i] && !done) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(STAB - 1)) done <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        sync1 <= 1'b0;
        sync2 <= 1'b0;
      end else begin
        sync1 <= done;
        sync2 <= sync1;
      end
    end

    assign osc_rdy[i] = sync2;
  end

endmodule

module osc_stab_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr,
  input logic [1:0] en_wdata,
  input logic [1:0] osc_en,
  input logic [1:0] osc_rdy,
  input logic [1:0] sys_sel,
  input logic       sel_chg
);

  a_r6_slow_sel_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sel == 2'd1 |-> osc_en[0] && osc_rdy[0]);

  a_r6_fast_sel_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sel == 2'd2 |-> osc_en[1] && osc_rdy[1]);

  a_r7_slow_kept: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && !en_wdata[0] && sys_sel == 2'd1 |=> osc_en[0]);

  a_r7_fast_kept: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && !en_wdata[1] && sys_sel == 2'd2 |=> osc_en[1]);

  a_r8_rdy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_rdy & ~osc_en) == 2'b00);

  a_r10_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sel != 2'd3);

  a_r9_chg_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_sel) |-> sel_chg);

  a_r9_chg_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |-> !$stable(sys_sel));

endmodule

bind osc_stab_ctrl osc_stab_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
  .osc_en(osc_en), .osc_rdy(osc_rdy), .sys_sel(sys_sel), .sel_chg(sel_chg)
);

// File: tb/osc_stab_ctrl_tb.sv
module osc_stab_ctrl_tb;
  localparam int LO_N = 256;
  localparam int HI_N = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_wr = 1'b0;
  logic [1:0] en_wdata = 2'b00;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_wdata = 2'b00;
  logic [1:0] osc_clk = 2'b00;
  logic [1:0] osc_valid = 2'b00;
  logic [1:0] osc_en, osc_rdy, sys_sel;
  logic       sel_chg;

  int checks = 0;
  int fails = 0;

  osc_stab_ctrl #(.LO_STAB(LO_N), .HI_STAB(HI_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .osc_clk(osc_clk),
    .osc_valid(osc_valid), .osc_en(osc_en), .osc_rdy(osc_rdy),
    .sys_sel(sys_sel), .sel_chg(sel_chg)
  );

  always #10 clk = ~clk;
  initial begin #15; forever begin osc_clk[0] = 1'b1; #30; osc_clk[0] = 1'b0; #30; end end
  initial begin #3;  forever begin osc_clk[1] = 1'b1; #8;  osc_clk[1] = 1'b0; #8;  end end

  // behavioural reference model
  logic [1:0] m_en = 2'b00, m_sel = 2'd0, m_psel = 2'd0;
  logic       m_pend = 1'b0, m_chg = 1'b0;
  logic [1:0] m_done = 2'b00, m_s1 = 2'b00, m_s2 = 2'b00;
  int         m_cnt [2] = '{0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 2'b00; m_sel = 2'd0; m_psel = 2'd0; m_pend = 1'b0; m_chg = 1'b0;
      m_s1 = 2'b00; m_s2 = 2'b00;
    end else begin
      automatic bit req = sel_wr && sel_wdata != 2'd3;
      automatic bit ready = (m_psel == 2'd0) || (m_psel == 2'd1 && m_s2[0]) ||
                            (m_psel == 2'd2 && m_s2[1]);
      automatic bit com = m_pend && ready && !req;
      automatic logic [1:0] nxt_en = m_en;
      automatic logic [1:0] hold;
      hold[0] = m_sel == 2'd1 || (com && m_psel == 2'd1);
      hold[1] = m_sel == 2'd2 || (com && m_psel == 2'd2);
      if (en_wr) nxt_en = en_wdata | hold;
      m_chg = 1'b0;
      if (req) begin m_pend = 1'b1; m_psel = sel_wdata; end
      else if (com) begin m_chg = (m_psel != m_sel); m_sel = m_psel; m_pend = 1'b0; end
      for (int i = 0; i < 2; i++) begin
        if (!nxt_en[i]) begin m_s1[i] = 1'b0; m_s2[i] = 1'b0; end
        else begin m_s2[i] = m_s1[i]; m_s1[i] = m_done[i] && m_en[i]; end
      end
      m_en = nxt_en;
    end
  end

  always @(posedge osc_clk[0]) begin
    if (!rst_n || !m_en[0]) begin m_cnt[0] = 0; m_done[0] = 1'b0; end
    else if (osc_valid[0] && !m_done[0]) begin
      m_cnt[0]++; if (m_cnt[0] == LO_N) m_done[0] = 1'b1;
    end
  end

  always @(posedge osc_clk[1]) begin
    if (!rst_n || !m_en[1]) begin m_cnt[1] = 0; m_done[1] = 1'b0; end
    else if (osc_valid[1] && !m_done[1]) begin
      m_cnt[1]++; if (m_cnt[1] == HI_N) m_done[1] = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R7", "osc_en", osc_en, m_en);
      chk("R3/R4/R8", "osc_rdy", osc_rdy, m_s2);
      chk("R6/R10", "sys_sel", sys_sel, m_sel);
      chk("R9", "sel_chg", sel_chg, m_chg);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [1:0] d);
    @(negedge clk); en_wr = 1'b1; en_wdata = d;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_sel(input logic [1:0] d);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = d;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset osc_en", osc_en, 0);
    chk("R1", "reset osc_rdy", osc_rdy, 0);
    chk("R1", "reset sys_sel", sys_sel, 0);
    chk("R1", "reset sel_chg", sel_chg, 0);

    // R2, R5: enable both; slow stays invalid for a while
    osc_valid = 2'b10;
    wr_en(2'b11);
    chk("R2", "both enabled", osc_en, 3);
    wr_sel(2'd1);
    repeat (20) @(posedge osc_clk[0]);
    @(negedge clk); osc_valid = 2'b11;
    repeat (HI_N + 8) @(posedge osc_clk[1]);
    cyc(3);
    chk("R4", "fast ready after count", osc_rdy[1], 1);
    chk("R6", "slow request still pending", sys_sel, 0);
    repeat (LO_N - 30) @(posedge osc_clk[0]);
    cyc(1);
    chk("R5", "slow not ready before valid count", osc_rdy[0], 0);
    repeat (40) @(posedge osc_clk[0]);
    cyc(3);
    chk("R3", "slow ready after count", osc_rdy[0], 1);
    chk("R6", "switched to slow", sys_sel, 1);

    // R7, R8: try to disable both while slow selected
    wr_en(2'b00);
    chk("R7", "selected slow kept enabled", osc_en, 1);
    chk("R8", "fast ready cleared", osc_rdy[1], 0);

    // R10: reserved ignored, newer request replaces pending
    wr_sel(2'd3);
    cyc(2);
    chk("R10", "reserved code ignored", sys_sel, 1);
    wr_sel(2'd2);
    cyc(4);
    chk("R6", "fast request pending while off", sys_sel, 1);
    wr_sel(2'd0);
    cyc(2);
    chk("R10", "override to boot", sys_sel, 0);

    // R8: re-enable fast needs full count again
    wr_en(2'b10);
    chk("R2", "slow cleared fast set", osc_en, 2);
    wr_sel(2'd2);
    repeat (HI_N - 6) @(posedge osc_clk[1]);
    cyc(1);
    chk("R8", "fast not ready early after restart", osc_rdy[1], 0);
    chk("R6", "still on boot", sys_sel, 0);
    repeat (12) @(posedge osc_clk[1]);
    cyc(4);
    chk("R8", "fast ready after full count", osc_rdy[1], 1);
    chk("R6", "switched to fast", sys_sel, 2);
    wr_en(2'b00);
    chk("R7", "selected fast kept", osc_en, 2);

    // R9: same-source request gives no pulse
    wr_sel(2'd2);
    chk("R9", "no pulse on same source", sel_chg, 0);
    cyc(3);
    chk("R9", "sel unchanged", sys_sel, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule